// File: doc/BRIEF.md
# Dual-Path Motion Search Dispatcher

This block schedules the candidate positions of one motion search level onto two matching paths that run side by side. It then keeps the cheapest candidate found on each path. A start pulse captures the frame kind, the level index, the previous motion direction, the predicted vector and the cost weight. One cycle later the level index is announced to the rest of the search engine. After that, the block issues one candidate vector per path per cycle. The external matching units answer in the same cycle with a distortion value for each path.

For bidirectional frames the two paths run in lockstep over the same position list. Path 0 matches against past reference data and path 1 against future reference data. For forward-only frames both paths see identical reference data, so the list is split: path 1 takes the even indices and path 0 takes the odd indices, and the search finishes in half the cycles. Each candidate is scored as its distortion plus a weighted vector-length penalty against the predicted vector. A merged final answer is formed from the two path winners. A one-cycle done pulse marks the point where all results are valid.

Top module: `msd_dispatch`

## Requirements
- R1: A start pulse while idle makes `lvl_bcast` high for exactly the next cycle, with `lvl_out` equal to the captured level. A start pulse while busy has no effect on the running search.
- R2: With `frame_b`=1, starting the cycle after `lvl_bcast`, both paths issue position indices 0..N-1 in ascending order, one per cycle. Both paths carry the same vector each cycle.
- R3: With `frame_b`=0, path 1 issues the even indices and path 0 the odd indices, paired per cycle as (2k, 2k+1). The run lasts ceil(N/2) cycles, and path 0 is idle in the last cycle when N is odd.
- R4: For levels 0, 1 and 3 the list is the full square window of side W=2R+1, so N=W*W. Index i maps to vector (i mod W - R, i div W - R).
- R5: For level 2 the list has N=4 entries. They are taken from the order (0,0), (+1,0), (-1,0), (0,+1), (0,-1), leaving out the unit step opposite the captured direction. Direction codes are 0=+x, 1=-x, 2=+y and 3=-y.
- R6: The cost of a candidate is its distortion plus lambda*(|x-px|+|y-py|). Lambda, px and py are captured at start.
- R7: Each path's result is the minimum-cost candidate it issued. On equal cost the earlier-issued candidate wins.
- R8: For forward-only frames the final result is the lower-cost path winner, with a tie going to the lower position index. For bidirectional frames the final result is path 0's winner.
- R9: `done` pulses for one cycle, in the cycle after the last issue. The results then hold until the next start.
- R10: After reset `busy`, `done`, `lvl_bcast` and both issue valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one level search (used only when idle) |
| frame_b | input | 1 | 1 = bidirectional frame, 0 = forward-only frame |
| level | input | 2 | Search level index |
| mv_dir | input | 2 | Previous motion direction code (level 2 only) |
| pred_mvx | input | MV_W | Predicted vector, x (signed) |
| pred_mvy | input | MV_W | Predicted vector, y (signed) |
| lambda | input | 4 | Weight for the vector cost |
| sod0 | input | SOD_W | Path 0 distortion for the vector currently issued |
| sod1 | input | SOD_W | Path 1 distortion for the vector currently issued |
| lvl_bcast | output | 1 | Level announcement strobe |
| lvl_out | output | 2 | Level index being searched |
| issue_v0 | output | 1 | Path 0 candidate valid |
| issue_mvx0 | output | MV_W | Path 0 candidate x |
| issue_mvy0 | output | MV_W | Path 0 candidate y |
| issue_v1 | output | 1 | Path 1 candidate valid |
| issue_mvx1 | output | MV_W | Path 1 candidate x |
| issue_mvy1 | output | MV_W | Path 1 candidate y |
| busy | output | 1 | Search in progress |
| done | output | 1 | Results valid strobe |
| best_mvx0 | output | MV_W | Path 0 winner x |
| best_mvy0 | output | MV_W | Path 0 winner y |
| best_cost0 | output | COST_W | Path 0 winner cost |
| best_mvx1 | output | MV_W | Path 1 winner x |
| best_mvy1 | output | MV_W | Path 1 winner y |
| best_cost1 | output | COST_W | Path 1 winner cost |
| fin_mvx | output | MV_W | Final vector x |
| fin_mvy | output | MV_W | Final vector y |
| fin_cost | output | COST_W | Final cost |

## Verification
A wrong step counter or a wrong mode register shows up at the issue ports. It appears in the very first run cycle as a wrong vector or a wrong valid pattern, or later as `done` arriving one cycle early or late. Faults in the cost or the winner update only show at `done`, as a winner vector or cost that differs from the minimum recomputed by the bench. Tie faults need equal distortions to become visible. The bench sweeps both frame kinds, every level, every direction code and several weights, and includes flat-distortion runs so that ties decide the outcome.

// File: rtl/msd_pkg.sv
package msd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BCAST = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } msd_state_e;

  localparam logic [1:0] DIR_POS_X = 2'd0;
  localparam logic [1:0] DIR_NEG_X = 2'd1;
  localparam logic [1:0] DIR_POS_Y = 2'd2;
  localparam logic [1:0] DIR_NEG_Y = 2'd3;

  localparam logic [1:0] LVL_DIAMOND = 2'd2;
  localparam int unsigned DIAMOND_N = 4;
endpackage

// File: rtl/msd_seq.sv
module msd_seq
  import msd_pkg::*;
#(
  parameter int R     = 2,
  parameter int MV_W  = 4,
  parameter int IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    frame_b,
  input  logic [1:0]              level,
  input  logic [1:0]              mv_dir,
  output logic                    busy,
  output logic                    lvl_bcast,
  output logic                    run,
  output logic                    done,
  output logic                    mode_b,
  output logic [1:0]              lvl_q,
  output logic [1:0]              iss_v,
  output logic [IDX_W-1:0]        iss_idx [2],
  output logic signed [MV_W-1:0]  iss_x [2],
  output logic signed [MV_W-1:0]  iss_y [2]
);
  localparam int W     = 2 * R + 1;
  localparam int NFULL = W * W;

  msd_state_e       state_q;
  logic [IDX_W-1:0] step_q;
  logic [1:0]       dir_q;
  logic [IDX_W-1:0] npos;
  logic [IDX_W-1:0] nsteps;
  logic [IDX_W-1:0] step_x2;

  // index -> candidate vector, packed as {x, y}
  function automatic logic [2*MV_W-1:0] pos_mv(input logic [IDX_W-1:0] idx,
                                               input logic [1:0] lvl,
                                               input logic [1:0] d);
    logic signed [MV_W-1:0] x;
    logic signed [MV_W-1:0] y;
    int unsigned j;
    int unsigned skip;
    if (lvl == LVL_DIAMOND) begin
      case (d)
        DIR_POS_X: skip = 2;
        DIR_NEG_X: skip = 1;
        DIR_POS_Y: skip = 4;
        default:   skip = 3;
      endcase
      j = int'(idx);
      if (j >= skip) j = j + 1;
      case (j)
        0:       begin x = '0;          y = '0;          end
        1:       begin x = MV_W'(1);    y = '0;          end
        2:       begin x = MV_W'(-1);   y = '0;          end
        3:       begin x = '0;          y = MV_W'(1);    end
        default: begin x = '0;          y = MV_W'(-1);   end
      endcase
    end else begin
      x = MV_W'(int'(idx) % W - R);
      y = MV_W'(int'(idx) / W - R);
    end
    return {x, y};
  endfunction

  assign npos    = (lvl_q == LVL_DIAMOND) ? IDX_W'(DIAMOND_N) : IDX_W'(NFULL);
  assign nsteps  = mode_b ? npos : IDX_W'((int'(npos) + 1) / 2);
  assign step_x2 = step_q << 1;

  assign busy      = (state_q != ST_IDLE);
  assign lvl_bcast = (state_q == ST_BCAST);
  assign run       = (state_q == ST_RUN);
  assign done      = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      mode_b  <= 1'b0;
      lvl_q   <= '0;
      dir_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          mode_b  <= frame_b;
          lvl_q   <= level;
          dir_q   <= mv_dir;
          state_q <= ST_BCAST;
        end
        ST_BCAST: begin
          step_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (step_q == IDX_W'(nsteps - 1'b1)) state_q <= ST_DONE;
          else step_q <= step_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    localparam logic [IDX_W-1:0] ODD = (p == 0) ? IDX_W'(1) : IDX_W'(0);
    assign iss_idx[p] = mode_b ? step_q : (step_x2 | ODD);
    assign iss_v[p]   = run && (iss_idx[p] < npos);
    assign {iss_x[p], iss_y[p]} = pos_mv(iss_idx[p], lvl_q, dir_q);
  end
endmodule

// File: rtl/msd_cost.sv
module msd_cost #(
  parameter int SOD_W  = 9,
  parameter int MV_W   = 4,
  parameter int COST_W = 19
) (
  input  logic [SOD_W-1:0]       sod,
  input  logic signed [MV_W-1:0] mvx,
  input  logic signed [MV_W-1:0] mvy,
  input  logic signed [MV_W-1:0] pmx,
  input  logic signed [MV_W-1:0] pmy,
  input  logic [3:0]             lambda,
  output logic [COST_W-1:0]      cost
);
  localparam int D_W = MV_W + 1;

  function automatic logic [D_W-1:0] absdiff(input logic signed [MV_W-1:0] a,
                                             input logic signed [MV_W-1:0] b);
    logic signed [D_W-1:0] d;
    d = D_W'(a) - D_W'(b);
    return d[D_W-1] ? D_W'(-d) : D_W'(d);
  endfunction

  function automatic logic [COST_W-1:0] total(input logic [SOD_W-1:0] s,
                                              input logic [D_W-1:0] dx,
                                              input logic [D_W-1:0] dy,
                                              input logic [3:0] lam);
    logic [COST_W-1:0] len;
    len = COST_W'(dx) + COST_W'(dy);
    return COST_W'(s) + COST_W'(lam) * len;
  endfunction

  assign cost = total(sod, absdiff(mvx, pmx), absdiff(mvy, pmy), lambda);
endmodule

// File: rtl/msd_best.sv
module msd_best #(
  parameter int MV_W   = 4,
  parameter int IDX_W  = 5,
  parameter int COST_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    valid,
  input  logic [COST_W-1:0]       cost,
  input  logic signed [MV_W-1:0]  mvx,
  input  logic signed [MV_W-1:0]  mvy,
  input  logic [IDX_W-1:0]        idx,
  output logic                    have,
  output logic [COST_W-1:0]       best_cost,
  output logic signed [MV_W-1:0]  best_x,
  output logic signed [MV_W-1:0]  best_y,
  output logic [IDX_W-1:0]        best_idx
);
  logic better;
  // strict compare: the first-issued candidate keeps a tie
  assign better = valid && (!have || (cost < best_cost));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have      <= 1'b0;
      best_cost <= '1;
      best_x    <= '0;
      best_y    <= '0;
      best_idx  <= '0;
    end else if (clr) begin
      have      <= 1'b0;
      best_cost <= '1;
      best_x    <= '0;
      best_y    <= '0;
      best_idx  <= '0;
    end else if (better) begin
      have      <= 1'b1;
      best_cost <= cost;
      best_x    <= mvx;
      best_y    <= mvy;
      best_idx  <= idx;
    end
  end
endmodule

// File: rtl/msd_merge.sv
module msd_merge #(
  parameter int IDX_W  = 5,
  parameter int COST_W = 19
) (
  input  logic              mode_b,
  input  logic              have0,
  input  logic              have1,
  input  logic [COST_W-1:0] cost0,
  input  logic [COST_W-1:0] cost1,
  input  logic [IDX_W-1:0]  idx0,
  input  logic [IDX_W-1:0]  idx1,
  output logic              take0
);
  function automatic logic wins(input logic [COST_W-1:0] ca, input logic [IDX_W-1:0] ia,
                                input logic [COST_W-1:0] cb, input logic [IDX_W-1:0] ib);
    return (ca < cb) || ((ca == cb) && (ia < ib));
  endfunction

  always_comb begin
    if (mode_b)      take0 = 1'b1;
    else if (!have1) take0 = 1'b1;
    else if (!have0) take0 = 1'b0;
    else             take0 = wins(cost0, idx0, cost1, idx1);
  end
endmodule

// File: rtl/msd_dispatch.sv
module msd_dispatch #(
  parameter int R      = 2,
  parameter int MV_W   = 4,
  parameter int SOD_W  = 9,
  parameter int COST_W = SOD_W + MV_W + 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    frame_b,
  input  logic [1:0]              level,
  input  logic [1:0]              mv_dir,
  input  logic signed [MV_W-1:0]  pred_mvx,
  input  logic signed [MV_W-1:0]  pred_mvy,
  input  logic [3:0]              lambda,
  input  logic [SOD_W-1:0]        sod0,
  input  logic [SOD_W-1:0]        sod1,
  output logic                    lvl_bcast,
  output logic [1:0]              lvl_out,
  output logic                    issue_v0,
  output logic signed [MV_W-1:0]  issue_mvx0,
  output logic signed [MV_W-1:0]  issue_mvy0,
  output logic                    issue_v1,
  output logic signed [MV_W-1:0]  issue_mvx1,
  output logic signed [MV_W-1:0]  issue_mvy1,
  output logic                    busy,
  output logic                    done,
  output logic signed [MV_W-1:0]  best_mvx0,
  output logic signed [MV_W-1:0]  best_mvy0,
  output logic [COST_W-1:0]       best_cost0,
  output logic signed [MV_W-1:0]  best_mvx1,
  output logic signed [MV_W-1:0]  best_mvy1,
  output logic [COST_W-1:0]       best_cost1,
  output logic signed [MV_W-1:0]  fin_mvx,
  output logic signed [MV_W-1:0]  fin_mvy,
  output logic [COST_W-1:0]       fin_cost
);
  localparam int W     = 2 * R + 1;
  localparam int IDX_W = $clog2(W * W + 1);

  // named internal events, also seen by the bound checker
  logic run_q;
  logic mode_b_q;
  logic have0, have1;
  logic take0;

  logic [1:0]              iss_v;
  logic [IDX_W-1:0]        iss_idx [2];
  logic signed [MV_W-1:0]  iss_x [2];
  logic signed [MV_W-1:0]  iss_y [2];
  logic [SOD_W-1:0]        sod_a [2];
  logic [COST_W-1:0]       cost_a [2];
  logic [COST_W-1:0]       bc [2];
  logic signed [MV_W-1:0]  bx [2];
  logic signed [MV_W-1:0]  by [2];
  logic [IDX_W-1:0]        bi [2];
  logic [1:0]              hv;

  logic signed [MV_W-1:0]  pmx_q, pmy_q;
  logic [3:0]              lam_q;

  msd_seq #(.R(R), .MV_W(MV_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_b(frame_b),
    .level(level), .mv_dir(mv_dir), .busy(busy), .lvl_bcast(lvl_bcast),
    .run(run_q), .done(done), .mode_b(mode_b_q), .lvl_q(lvl_out),
    .iss_v(iss_v), .iss_idx(iss_idx), .iss_x(iss_x), .iss_y(iss_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmx_q <= '0;
      pmy_q <= '0;
      lam_q <= '0;
    end else if (start && !busy) begin
      pmx_q <= pred_mvx;
      pmy_q <= pred_mvy;
      lam_q <= lambda;
    end
  end

  assign sod_a[0] = sod0;
  assign sod_a[1] = sod1;

  for (genvar p = 0; p < 2; p++) begin : g_path
    msd_cost #(.SOD_W(SOD_W), .MV_W(MV_W), .COST_W(COST_W)) u_cost (
      .sod(sod_a[p]), .mvx(iss_x[p]), .mvy(iss_y[p]),
      .pmx(pmx_q), .pmy(pmy_q), .lambda(lam_q), .cost(cost_a[p])
    );
    msd_best #(.MV_W(MV_W), .IDX_W(IDX_W), .COST_W(COST_W)) u_best (
      .clk(clk), .rst_n(rst_n), .clr(lvl_bcast), .valid(iss_v[p]),
      .cost(cost_a[p]), .mvx(iss_x[p]), .mvy(iss_y[p]), .idx(iss_idx[p]),
      .have(hv[p]), .best_cost(bc[p]), .best_x(bx[p]), .best_y(by[p]),
      .best_idx(bi[p])
    );
  end

  assign have0 = hv[0];
  assign have1 = hv[1];

  msd_merge #(.IDX_W(IDX_W), .COST_W(COST_W)) u_merge (
    .mode_b(mode_b_q), .have0(have0), .have1(have1),
    .cost0(bc[0]), .cost1(bc[1]), .idx0(bi[0]), .idx1(bi[1]), .take0(take0)
  );

  assign issue_v0   = iss_v[0];
  assign issue_mvx0 = iss_x[0];
  assign issue_mvy0 = iss_y[0];
  assign issue_v1   = iss_v[1];
  assign issue_mvx1 = iss_x[1];
  assign issue_mvy1 = iss_y[1];

  assign best_mvx0  = bx[0];
  assign best_mvy0  = by[0];
  assign best_cost0 = bc[0];
  assign best_mvx1  = bx[1];
  assign best_mvy1  = by[1];
  assign best_cost1 = bc[1];

  assign fin_mvx  = take0 ? bx[0] : bx[1];
  assign fin_mvy  = take0 ? by[0] : by[1];
  assign fin_cost = take0 ? bc[0] : bc[1];
endmodule

// File: rtl/msd_dispatch_chk.sv
module msd_dispatch_chk #(
  parameter int COST_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              lvl_bcast,
  input logic              issue_v0,
  input logic              issue_v1,
  input logic              run_q,
  input logic              mode_b_q,
  input logic              have0,
  input logic              have1,
  input logic [COST_W-1:0] best_cost0,
  input logic [COST_W-1:0] best_cost1,
  input logic [COST_W-1:0] fin_cost
);
  assert_bcast_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> lvl_bcast);

  assert_bcast_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_bcast |=> !lvl_bcast);

  assert_lockstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_b_q) |-> (issue_v0 == issue_v1));

  assert_even_path_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> issue_v1);

  assert_best_never_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ((best_cost0 <= $past(best_cost0)) && (best_cost1 <= $past(best_cost1))));

  assert_final_is_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_b_q && have0 && have1) |-> ((fin_cost <= best_cost0) && (fin_cost <= best_cost1)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!issue_v0 && !issue_v1 && !done && !lvl_bcast));
endmodule

bind msd_dispatch msd_dispatch_chk #(.COST_W(COST_W)) u_chk (.*);

// File: tb/sim_msd_dispatch.sv
module sim_msd_dispatch;
  localparam int R = 2;
  localparam int W = 2 * R + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic frame_b = 1'b0;
  logic [1:0] level = '0;
  logic [1:0] mv_dir = '0;
  logic signed [3:0] pred_mvx = '0, pred_mvy = '0;
  logic [3:0] lambda = '0;
  logic [8:0] sod0, sod1;
  logic lvl_bcast, issue_v0, issue_v1, busy, done;
  logic [1:0] lvl_out;
  logic signed [3:0] issue_mvx0, issue_mvy0, issue_mvx1, issue_mvy1;
  logic signed [3:0] best_mvx0, best_mvy0, best_mvx1, best_mvy1, fin_mvx, fin_mvy;
  logic [18:0] best_cost0, best_cost1, fin_cost;

  int n_run = 0;
  int n_fail = 0;
  int seed = 0;

  always #5 clk = ~clk;

  function automatic int sod_model(input int path, input int x, input int y);
    if (seed == 0) return 50;
    return ((x + 8) * (11 + seed) + (y + 8) * (7 + path * 4) + path * 13) % 97 + 3;
  endfunction

  assign sod0 = 9'(sod_model(0, int'(issue_mvx0), int'(issue_mvy0)));
  assign sod1 = 9'(sod_model(1, int'(issue_mvx1), int'(issue_mvy1)));

  msd_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_b(frame_b), .level(level),
    .mv_dir(mv_dir), .pred_mvx(pred_mvx), .pred_mvy(pred_mvy), .lambda(lambda),
    .sod0(sod0), .sod1(sod1), .lvl_bcast(lvl_bcast), .lvl_out(lvl_out),
    .issue_v0(issue_v0), .issue_mvx0(issue_mvx0), .issue_mvy0(issue_mvy0),
    .issue_v1(issue_v1), .issue_mvx1(issue_mvx1), .issue_mvy1(issue_mvy1),
    .busy(busy), .done(done), .best_mvx0(best_mvx0), .best_mvy0(best_mvy0),
    .best_cost0(best_cost0), .best_mvx1(best_mvx1), .best_mvy1(best_mvy1),
    .best_cost1(best_cost1), .fin_mvx(fin_mvx), .fin_mvy(fin_mvy), .fin_cost(fin_cost)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected candidate list
  int lx[32], ly[32], ln;

  task automatic build_list(input int lvl, input int d);
    int cx[5], cy[5], ox, oy;
    ln = 0;
    if (lvl == 2) begin
      cx = '{0, 1, -1, 0, 0};
      cy = '{0, 0, 0, 1, -1};
      ox = (d == 0) ? -1 : (d == 1) ? 1 : 0;   // opposite of the direction
      oy = (d == 2) ? -1 : (d == 3) ? 1 : 0;
      for (int k = 0; k < 5; k++)
        if (!(cx[k] == ox && cy[k] == oy)) begin lx[ln] = cx[k]; ly[ln] = cy[k]; ln++; end
    end else begin
      for (int yy = -R; yy <= R; yy++)
        for (int xx = -R; xx <= R; xx++) begin lx[ln] = xx; ly[ln] = yy; ln++; end
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic one_search(input bit fb, input int lvl, input int d, input int lam,
                            input int px, input int py, input bit poke);
    int steps, e0, e1, c, bc0, bc1, bi0, bi1, bx0, by0, bx1, by1;
    int fc, fx, fy;
    bit seq_ok, v0e, v1e;
    build_list(lvl, d);
    steps = fb ? ln : (ln + 1) / 2;
    bc0 = -1; bc1 = -1; bi0 = 0; bi1 = 0; bx0 = 0; by0 = 0; bx1 = 0; by1 = 0;
    @(negedge clk);
    frame_b = fb; level = 2'(lvl); mv_dir = 2'(d); lambda = 4'(lam);
    pred_mvx = 4'(px); pred_mvy = 4'(py); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    frame_b = ~fb; lambda = 4'(lam + 3);   // changes after capture must not matter (R6)
    chk(lvl_bcast === 1'b1, "R1", "lvl_bcast", int'(lvl_bcast), 1);
    chk(lvl_out == 2'(lvl), "R1", "lvl_out", int'(lvl_out), lvl);
    seq_ok = 1'b1;
    for (int s = 0; s < steps; s++) begin
      @(negedge clk);
      e1 = fb ? s : 2 * s;
      e0 = fb ? s : 2 * s + 1;
      v1e = 1'b1;
      v0e = (e0 < ln);
      if (issue_v1 !== v1e || issue_v0 !== v0e || done !== 1'b0) seq_ok = 1'b0;
      if (int'(issue_mvx1) != lx[e1] || int'(issue_mvy1) != ly[e1]) seq_ok = 1'b0;
      if (v0e && (int'(issue_mvx0) != lx[e0] || int'(issue_mvy0) != ly[e0])) seq_ok = 1'b0;
      // expected winners from the scoring rule
      c = sod_model(1, lx[e1], ly[e1]) + lam * (iabs(lx[e1] - px) + iabs(ly[e1] - py));
      if (bc1 < 0 || c < bc1) begin bc1 = c; bi1 = e1; bx1 = lx[e1]; by1 = ly[e1]; end
      if (v0e) begin
        c = sod_model(0, lx[e0], ly[e0]) + lam * (iabs(lx[e0] - px) + iabs(ly[e0] - py));
        if (bc0 < 0 || c < bc0) begin bc0 = c; bi0 = e0; bx0 = lx[e0]; by0 = ly[e0]; end
      end
      start = poke && (s == 0);   // start while busy must be ignored (R1)
    end
    start = 1'b0;
    if (fb) chk(seq_ok, "R2", "bidir issue sequence", int'(seq_ok), 1);
    else    chk(seq_ok, "R3", "split issue sequence", int'(seq_ok), 1);
    if (lvl == 2) chk(seq_ok && ln == 4, "R5", "diamond list", ln, 4);
    else          chk(seq_ok && ln == W * W, "R4", "window list", ln, W * W);
    @(negedge clk);
    chk(done === 1'b1 && issue_v0 === 1'b0 && issue_v1 === 1'b0, "R9", "done after last issue", int'(done), 1);
    chk(int'(best_cost0) == bc0 && int'(best_mvx0) == bx0 && int'(best_mvy0) == by0,
        "R7", "path0 cost", int'(best_cost0), bc0);
    chk(int'(best_cost1) == bc1 && int'(best_mvx1) == bx1 && int'(best_mvy1) == by1,
        "R6", "path1 cost", int'(best_cost1), bc1);
    if (fb || bc0 < bc1 || (bc0 == bc1 && bi0 < bi1)) begin fc = bc0; fx = bx0; fy = by0; end
    else begin fc = bc1; fx = bx1; fy = by1; end
    chk(int'(fin_cost) == fc && int'(fin_mvx) == fx && int'(fin_mvy) == fy,
        "R8", "final cost", int'(fin_cost), fc);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && int'(fin_cost) == fc && int'(best_cost0) == bc0,
        "R9", "hold after done", int'(fin_cost), fc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && lvl_bcast === 1'b0 && issue_v0 === 1'b0 && issue_v1 === 1'b0,
        "R10", "reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && issue_v0 === 1'b0 && issue_v1 === 1'b0, "R10", "idle after reset", int'(busy), 0);
    for (int sd = 0; sd < 3; sd++) begin
      seed = sd;
      for (int fb = 0; fb < 2; fb++)
        for (int lv = 0; lv < 4; lv++)
          for (int d = 0; d < 4; d++)
            for (int li = 0; li < 3; li++) begin
              if (lv != 2 && d != 0 && li != 1) continue;
              one_search(fb[0], lv, d, (li == 0) ? 0 : (li == 1) ? 5 : 15,
                         li - 1, d - 2, (d == 1));
            end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule